// File: doc/BRIEF.md
# DMA channel address and count generator

This block keeps the working state of one DMA channel: a 16-bit current address, a 16-bit page that supplies the upper bus bits, a 16-bit transfer count, a 22-bit stop value and a small mode register. Each accepted transfer strobe moves the address by a step that depends on the device transfer size. The direction bit sets whether it moves up or down. Each accepted strobe also lowers the count by one. The 32-bit bus address is formed from the page and the current address. In the 16-bit word-counting mode the current address is shifted left by one bit, and the lowest page bit is not used.

Software loads the registers through a single-cycle write port. A master clear input, like reset, returns every register to its default, including the default 8-bit byte-counting mode. An optional stop compare halts the channel when the next address reaches a programmed dword boundary. This supports ring buffers.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, or in the cycle after `mclr` is high, bus_addr is 0, cur_count is 0, tc and stop_hit are 0, and the mode is size 0, increment, stop compare off.
- R2: The mode register (wr_sel 4) holds the size in bits 1:0. Each accepted transfer moves the current address by 1 for size 0 (8-bit bytes), by 1 for size 1 (16-bit words, shifted), by 2 for size 2 (16-bit bytes) and by 4 for size 3 (32-bit bytes).
- R3: When mode bit 2 is 1, the address decreases on each transfer; when it is 0, the address increases.
- R4: The current address wraps within its 16 bits, and a transfer never changes the page part of bus_addr.
- R5: Each accepted transfer lowers cur_count by exactly 1, and the count wraps from 0 to 16'hFFFF.
- R6: tc is high for exactly one cycle, in the cycle after an accepted transfer that started with cur_count equal to 0. It is low at all other times.
- R7: For sizes 0, 2 and 3, bus_addr equals {page[15:0], address[15:0]}.
- R8: For size 1, bus_addr equals {page[15:1], address[15:0], 1'b0}.
- R9: When mode bit 3 is 1, a transfer completes normally. If the bus address after that transfer, bits 23:2, equals the stop value (wr_sel 3, bits 21:0), stop_hit rises in the next cycle. Later transfers then leave bus_addr and cur_count unchanged until the address, stop value or mode is written, or until a master clear.
- R10: When mode bit 3 is 0, the stop value has no effect, and the address advances past it.
- R11: Writes use wr_sel 0 for the address (bits 15:0), 1 for the count, 2 for the page, 3 for the stop value and 4 for the mode. A write in the same cycle as a transfer strobe takes effect, and that strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclr | input | 1 | Master clear; returns all registers to their defaults |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| xfer | input | 1 | One transfer cycle has completed |
| bus_addr | output | 32 | Bus address formed from page and current address |
| cur_count | output | 16 | Current transfer count |
| tc | output | 1 | Terminal-count pulse |
| stop_hit | output | 1 | Stop address reached; the channel is frozen |

## Verification
Each transfer changes the address and count state, and that state reaches bus_addr and cur_count one clock after the strobe. A wrong step, a wrong direction, or a carry into the page therefore shows up at the ports on the very next cycle. A fault in the mapping shows as a wrong bit pattern in the page field or in bit 0 as soon as a mode is written. A fault in the count or in the stop state may stay hidden until the count crosses zero or the next address lands on the stop boundary. For that reason the bench drives both crossings on purpose and watches tc and stop_hit in the cycle after the transfer that causes them.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_W16 = 2'd1,
    SZ_B16 = 2'd2,
    SZ_B32 = 2'd3
  } xsize_e;

  // bit 3: stop compare enable, bit 2: decrement, bits 1:0: size
  typedef struct packed {
    logic   stop_en;
    logic   dec;
    xsize_e size;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] SEL_ADDR = 3'd0;
  localparam logic [2:0] SEL_CNT  = 3'd1;
  localparam logic [2:0] SEL_PAGE = 3'd2;
  localparam logic [2:0] SEL_STOP = 3'd3;
  localparam logic [2:0] SEL_MODE = 3'd4;

  function automatic logic [2:0] step_of(xsize_e s);
    case (s)
      SZ_B16:  step_of = 3'd2;
      SZ_B32:  step_of = 3'd4;
      default: step_of = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/dma_ag_step.sv
module dma_ag_step
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  xsize_e            size,
  input  logic              dec,
  output logic [ADDR_W-1:0] next_addr
);

  logic [ADDR_W-1:0] stp;

  always_comb begin
    stp = ADDR_W'(step_of(size));
    if (dec) next_addr = addr - stp;
    else     next_addr = addr + stp;
  end

endmodule

// File: rtl/dma_ag_map.sv
module dma_ag_map #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 16,
  localparam int BUS_W = ADDR_W + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  input  logic              shifted,
  output logic [BUS_W-1:0]  bus
);

  always_comb begin
    if (shifted) bus = {page[PAGE_W-1:1], addr, 1'b0};
    else         bus = {page, addr};
  end

endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] count,
  output logic             tc
);

  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= dec_en && (cnt_q == '0);
      if (load)        cnt_q <= load_val;
      else if (dec_en) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
  assign tc    = tc_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 16,
  parameter int CNT_W  = 16,
  parameter int STOP_W = 22,
  parameter int DATA_W = 32,
  localparam int BUS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [BUS_W-1:0]  bus_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              tc,
  output logic              stop_hit
);

  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] page_q;
  logic [STOP_W-1:0] stop_q;
  mode_t             mode_q;
  logic              stopped_q;

  logic [ADDR_W-1:0] addr_nx;
  logic [BUS_W-1:0]  bus_nx;
  logic              shifted;
  logic              clr;
  logic              adv;
  logic              stop_match;
  logic              unused_bits;

  assign clr         = rst || mclr;
  assign shifted     = (mode_q.size == SZ_W16);
  assign adv         = xfer && !wr_en && !mclr && !stopped_q;
  assign unused_bits = ^wr_data[DATA_W-1:STOP_W];

  dma_ag_step #(.ADDR_W(ADDR_W)) step_i (
    .addr      (addr_q),
    .size      (mode_q.size),
    .dec       (mode_q.dec),
    .next_addr (addr_nx)
  );

  dma_ag_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) map_cur_i (
    .addr    (addr_q),
    .page    (page_q),
    .shifted (shifted),
    .bus     (bus_addr)
  );

  dma_ag_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) map_nx_i (
    .addr    (addr_nx),
    .page    (page_q),
    .shifted (shifted),
    .bus     (bus_nx)
  );

  assign stop_match = mode_q.stop_en && (bus_nx[STOP_W+1:2] == stop_q);

  always_ff @(posedge clk) begin
    if (clr) begin
      addr_q    <= '0;
      page_q    <= '0;
      stop_q    <= '0;
      mode_q    <= '{stop_en: 1'b0, dec: 1'b0, size: SZ_B8};
      stopped_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ADDR: begin
          addr_q    <= wr_data[ADDR_W-1:0];
          stopped_q <= 1'b0;
        end
        SEL_PAGE: page_q <= wr_data[PAGE_W-1:0];
        SEL_STOP: begin
          stop_q    <= wr_data[STOP_W-1:0];
          stopped_q <= 1'b0;
        end
        SEL_MODE: begin
          mode_q    <= mode_t'(wr_data[MODE_W-1:0]);
          stopped_q <= 1'b0;
        end
        default: ;
      endcase
    end else if (adv) begin
      addr_q <= addr_nx;
      if (stop_match) stopped_q <= 1'b1;
    end
  end

  dma_ag_count #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .clr      (clr),
    .load     (wr_en && (wr_sel == SEL_CNT)),
    .load_val (wr_data[CNT_W-1:0]),
    .dec_en   (adv),
    .count    (cur_count),
    .tc       (tc)
  );

  assign stop_hit = stopped_q;

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mclr,
  input logic             wr_en,
  input logic             xfer,
  input logic [BUS_W-1:0] bus_addr,
  input logic [CNT_W-1:0] cur_count,
  input logic             tc,
  input logic             stop_hit,
  input logic [1:0]       size
);

  // R1
  mclr_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (bus_addr == '0 && cur_count == '0 && !stop_hit && !tc));

  // R6
  tc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tc |-> ($past(xfer) && !$past(wr_en) && !$past(mclr) && !$past(stop_hit)));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wr_en && !mclr) |=> (bus_addr[BUS_W-1:17] == $past(bus_addr[BUS_W-1:17])));

  // R8
  shift_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (size == 2'd1) |-> !bus_addr[0]);

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_hit && !wr_en && !mclr) |=> ($stable(bus_addr) && $stable(cur_count)));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wr_en && !mclr && !stop_hit) |=> (cur_count == $past(cur_count) - 1'b1));

endmodule

bind dma_addr_gen dma_addr_gen_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mclr      (mclr),
  .wr_en     (wr_en),
  .xfer      (xfer),
  .bus_addr  (bus_addr),
  .cur_count (cur_count),
  .tc        (tc),
  .stop_hit  (stop_hit),
  .size      (mode_q.size)
);

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mclr = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        xfer = 1'b0;
  logic [31:0] bus_addr;
  logic [15:0] cur_count;
  logic        tc;
  logic        stop_hit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dma_addr_gen dut_i (
    .clk(clk), .rst(rst), .mclr(mclr), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .xfer(xfer), .bus_addr(bus_addr),
    .cur_count(cur_count), .tc(tc), .stop_hit(stop_hit)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic        dec;
    logic [15:0] page;
    logic [15:0] addr;
    logic [15:0] cnt;
    logic [3:0]  n;
    logic [31:0] exp_bus;
    logic [15:0] exp_cnt;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R2 R7: bytes, increment
    '{2'd0, 1'b0, 16'h1234, 16'h0010, 16'd5,  4'd3, 32'h1234_0013, 16'd2},
    // R2 R8: words shifted, increment, page LSB dropped
    '{2'd1, 1'b0, 16'h1235, 16'h0010, 16'd4,  4'd2, 32'h1234_0024, 16'd2},
    // R2 R7: 16-bit bytes, step 2
    '{2'd2, 1'b0, 16'h0001, 16'h0100, 16'd10, 4'd3, 32'h0001_0106, 16'd7},
    // R2 R3: 32-bit, step 4, decrement
    '{2'd3, 1'b1, 16'h00FF, 16'h0020, 16'd3,  4'd2, 32'h00FF_0018, 16'd1},
    // R4: wrap upward without page carry
    '{2'd3, 1'b0, 16'h0002, 16'hFFFE, 16'd1,  4'd1, 32'h0002_0002, 16'd0},
    // R4 R5: wrap downward, count wraps
    '{2'd0, 1'b1, 16'h0003, 16'h0000, 16'd0,  4'd1, 32'h0003_FFFF, 16'hFFFF},
    // R3 R8: shifted, decrement
    '{2'd1, 1'b1, 16'h8001, 16'h8000, 16'd2,  4'd1, 32'h8000_FFFE, 16'd1}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_xfer(input int n);
    for (int k = 0; k < n; k++) begin
      xfer = 1'b1;
      @(negedge clk);
      xfer = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] cnt_before;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset bus_addr", bus_addr, 32'd0);
    chk("R1 reset cur_count", {16'd0, cur_count}, 32'd0);
    chk("R1 reset tc", {31'd0, tc}, 32'd0);
    chk("R1 reset stop_hit", {31'd0, stop_hit}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_wr(3'd4, {29'd0, VECS[i].dec, VECS[i].size});
      do_wr(3'd2, {16'd0, VECS[i].page});
      do_wr(3'd0, {16'd0, VECS[i].addr});
      do_wr(3'd1, {16'd0, VECS[i].cnt});
      do_xfer(int'(VECS[i].n));
      chk($sformatf("R2/R3/R4/R7/R8 vector %0d bus_addr", i), bus_addr, VECS[i].exp_bus);
      chk($sformatf("R5 vector %0d cur_count", i), {16'd0, cur_count}, {16'd0, VECS[i].exp_cnt});
    end

    // R6: terminal count pulse
    do_wr(3'd4, 32'd0);
    do_wr(3'd1, 32'd2);
    xfer = 1'b1; @(negedge clk); xfer = 1'b0;
    chk("R6 no tc when count nonzero", {31'd0, tc}, 32'd0);
    do_wr(3'd1, 32'd0);
    xfer = 1'b1; @(negedge clk); xfer = 1'b0;
    chk("R6 tc after transfer from zero", {31'd0, tc}, 32'd1);
    chk("R5 count wraps to all ones", {16'd0, cur_count}, 32'h0000_FFFF);
    @(negedge clk);
    chk("R6 tc lasts one cycle", {31'd0, tc}, 32'd0);

    // R9: stop compare
    do_wr(3'd4, 32'b1011);
    do_wr(3'd3, 32'd2);
    do_wr(3'd2, 32'd0);
    do_wr(3'd0, 32'd0);
    do_wr(3'd1, 32'd10);
    do_xfer(1);
    chk("R9 no stop before boundary", {31'd0, stop_hit}, 32'd0);
    do_xfer(1);
    chk("R9 stop_hit at boundary", {31'd0, stop_hit}, 32'd1);
    chk("R9 address at boundary", bus_addr, 32'h0000_0008);
    do_xfer(2);
    chk("R9 frozen address", bus_addr, 32'h0000_0008);
    chk("R9 frozen count", {16'd0, cur_count}, 32'd8);
    do_wr(3'd0, 32'd0);
    chk("R9 address write releases stop", {31'd0, stop_hit}, 32'd0);

    // R10: compare disabled
    do_wr(3'd4, 32'b0011);
    do_xfer(3);
    chk("R10 address passes stop value", bus_addr, 32'h0000_000C);
    chk("R10 no stop_hit", {31'd0, stop_hit}, 32'd0);

    // R11: write wins over transfer
    cnt_before = cur_count;
    xfer = 1'b1;
    do_wr(3'd0, 32'h0000_0040);
    xfer = 1'b0;
    chk("R11 write taken", bus_addr, 32'h0000_0040);
    chk("R11 transfer ignored", {16'd0, cur_count}, {16'd0, cnt_before});

    // R1: master clear
    do_wr(3'd4, 32'd1);
    do_wr(3'd2, 32'd5);
    do_wr(3'd0, 32'h10);
    mclr = 1'b1; @(negedge clk); mclr = 1'b0;
    chk("R1 mclr bus_addr", bus_addr, 32'd0);
    chk("R1 mclr cur_count", {16'd0, cur_count}, 32'd0);
    do_wr(3'd2, 32'd3);
    do_wr(3'd0, 32'h10);
    chk("R1 mode back to unshifted", bus_addr, 32'h0003_0010);
    do_xfer(1);
    chk("R1 mode back to byte increment", bus_addr, 32'h0003_0011);

    report();
  end

endmodule